// File: doc/BRIEF.md
# Receive Buffer Credit Tracker

This block keeps a running count of free receive buffers for several flow-control units. Each unit serves one pair of DMA channels: channel c belongs to unit c>>1. Software hands buffers to a unit by writing a count into that unit's allocation register. The receive engine pulses a per-channel consume line each time it fills a descriptor, and every pulse takes one credit away.

Each unit has two programmable thresholds. Backpressure toward the packet source turns on when the free count falls below the low threshold. It turns off only once the count has climbed back to the high threshold, so the gap between the two thresholds gives hysteresis. Software usually sets the low threshold to a third of the ring size and the high threshold to two thirds. A force bit in the allocation word releases the unit at once by filling its count to the maximum.

Each unit also drives its current count as a plain output, so the rest of the chip can see it. A global configuration word holds a master enable and one enable bit per unit. A unit that is not enabled holds its count, ignores allocations and consumes, and keeps its backpressure low.

Top module: `fc_credit_tracker`

## Requirements
- R1: After reset, every count is 0, every backpressure output is 0, and the configuration word and all thresholds are 0.
- R2: Writes decode as follows. Address 0x00 is the configuration word. For unit u, the low threshold is at 0x04+12u, the high threshold at 0x08+12u and the allocation register at 0x0C+12u. A write to any other address changes nothing.
- R3: Unit u is active only when configuration bit 0 (master) and configuration bit u+1 are both 1. An inactive unit holds backpressure at 0 and keeps its count, whatever allocations or consumes arrive.
- R4: An allocation write to an active unit adds data bits [CNT_W-1:0] to its count. The result saturates at 2^CNT_W-1.
- R5: A consume pulse on channel c takes one credit from unit c>>1, so both channels of a pair together take two in a cycle. The count never goes below 0. An allocation and consumes in the same cycle are netted against each other before saturation.
- R6: An allocation write with data bit 31 set to an active unit loads the maximum count. It overrides any add amount and any consume in the same cycle.
- R7: Backpressure is registered and updates on the same edge as the count. It sets when the new count is below the low threshold. Otherwise it clears when the new count is at or above the high threshold, and otherwise keeps its value.
- R8: A cycle whose consumes exceed the available credits (count plus allocation) sets backpressure, even when the low threshold is 0.
- R9: Units are independent. Writes and consumes aimed at one unit leave every other unit's count and backpressure unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Byte address of the write |
| wr_data_i | input | 32 | Write data |
| consume_i | input | 2*NUM_UNITS | One pulse per filled descriptor, one bit per channel |
| bp_o | output | NUM_UNITS | Backpressure, one bit per unit |
| credit_o | output | NUM_UNITS*CNT_W | Free count of each unit, unit u in bits [u*CNT_W +: CNT_W] |

## Verification
The bench builds the block with two units and a 4-bit count. With those values the full range from 0 to 15 is small enough to reach saturation and the zero floor every few cycles. The bench sweeps every pair of low and high thresholds, 256 combinations, including the inverted and zero cases, and runs a pseudo-random stream of allocations, forces, enable toggles and paired consumes under each pair. A cycle-level model in the bench tracks both units, so the test can check isolation between the two units and the netting of two consumes against an allocation on every cycle.

// File: rtl/fc_pkg.sv
package fc_pkg;
  typedef struct packed {
    logic lo;
    logic hi;
    logic alloc;
  } fc_wr_t;

  localparam int unsigned DATA_W    = 32;
  localparam int unsigned FORCE_BIT = 31;
endpackage

// File: rtl/fc_reg_decode.sv
module fc_reg_decode
  import fc_pkg::*;
#(
  parameter int unsigned NUM_UNITS = 8,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_en_i,
  input  logic [ADDR_W-1:0]               wr_addr_i,
  output logic                            cfg_we_o,
  output fc_wr_t [NUM_UNITS-1:0]          unit_we_o
);
  localparam int unsigned STRB_W = 3 * NUM_UNITS + 1;

  assign cfg_we_o = wr_en_i && (wr_addr_i == '0);

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(4 + 12 * u);
    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(8 + 12 * u);
    localparam logic [ADDR_W-1:0] AL_A = ADDR_W'(12 + 12 * u);
    assign unit_we_o[u].lo    = wr_en_i && (wr_addr_i == LO_A);
    assign unit_we_o[u].hi    = wr_en_i && (wr_addr_i == HI_A);
    assign unit_we_o[u].alloc = wr_en_i && (wr_addr_i == AL_A);
  end

  logic [STRB_W-1:0] strb_all;
  assign strb_all = {unit_we_o, cfg_we_o};

  // at most one register selected per write
  assert_one_target_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(strb_all));
  assert_idle_no_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |-> (strb_all == '0));
endmodule

// File: rtl/fc_consume_map.sv
module fc_consume_map #(
  parameter int unsigned NUM_UNITS = 8,
  localparam int unsigned NUM_CHANS = 2 * NUM_UNITS
) (
  input  logic [NUM_CHANS-1:0]           consume_i,
  output logic [NUM_UNITS-1:0][1:0]      take_o
);
  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_pair
    assign take_o[u] = {1'b0, consume_i[2*u]} + {1'b0, consume_i[2*u+1]};
  end
endmodule

// File: rtl/fc_unit.sv
module fc_unit
  import fc_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               active_i,
  input  fc_wr_t             wr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [1:0]         take_i,
  output logic [CNT_W-1:0]   cnt_o,
  output logic               bp_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam int unsigned SUM_W = CNT_W + 1;

  logic [CNT_W-1:0] lo_q, hi_q, cnt_q, cnt_n;
  logic             bp_q, bp_n;
  logic [CNT_W-1:0] add;
  logic [SUM_W-1:0] sum, take_ext, diff;
  logic             force_req, short;

  assign add       = wr_i.alloc ? wdata_i[CNT_W-1:0] : '0;
  assign force_req = wr_i.alloc && wdata_i[FORCE_BIT];
  assign sum       = {1'b0, cnt_q} + {1'b0, add};
  assign take_ext  = SUM_W'(take_i);
  assign diff      = sum - take_ext;
  assign short     = !force_req && (sum < take_ext);

  always_comb begin
    if (force_req)                      cnt_n = CNT_MAX;
    else if (short)                     cnt_n = '0;
    else if (diff > {1'b0, CNT_MAX})    cnt_n = CNT_MAX;
    else                                cnt_n = diff[CNT_W-1:0];
  end

  always_comb begin
    if (!active_i)          bp_n = 1'b0;
    else if (short)         bp_n = 1'b1;
    else if (cnt_n < lo_q)  bp_n = 1'b1;
    else if (cnt_n >= hi_q) bp_n = 1'b0;
    else                    bp_n = bp_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q  <= '0;
      hi_q  <= '0;
      cnt_q <= '0;
      bp_q  <= 1'b0;
    end else begin
      if (wr_i.lo) lo_q <= wdata_i[CNT_W-1:0];
      if (wr_i.hi) hi_q <= wdata_i[CNT_W-1:0];
      if (active_i) cnt_q <= cnt_n;
      bp_q <= bp_n;
    end
  end

  assign cnt_o = cnt_q;
  assign bp_o  = bp_q;

  assert_off_no_bp_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> !bp_q);
  assert_off_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> $stable(cnt_q));
  assert_no_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !force_req && take_i == 2'd0) |=> cnt_q >= $past(cnt_q));
  assert_no_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !wr_i.alloc && take_i != 2'd0) |=> cnt_q <= $past(cnt_q));
  assert_force_max_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && force_req) |=> cnt_q == CNT_MAX);
  assert_rise_below_lo_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bp_q) |-> (cnt_q < $past(lo_q)) || (cnt_q == '0));
  assert_fall_at_hi_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(bp_q) && $past(active_i)) |-> cnt_q >= $past(hi_q));
  assert_empty_bp_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && cnt_q == '0 && !wr_i.alloc && take_i != 2'd0) |=> (bp_q && cnt_q == '0));
endmodule

// File: rtl/fc_credit_tracker.sv
module fc_credit_tracker
  import fc_pkg::*;
#(
  parameter int unsigned NUM_UNITS = 8,
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned ADDR_W    = 8,
  localparam int unsigned NUM_CHANS = 2 * NUM_UNITS,
  localparam int unsigned CFG_W     = NUM_UNITS + 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [ADDR_W-1:0]            wr_addr_i,
  input  logic [DATA_W-1:0]            wr_data_i,
  input  logic [NUM_CHANS-1:0]         consume_i,
  output logic [NUM_UNITS-1:0]         bp_o,
  output logic [NUM_UNITS*CNT_W-1:0]   credit_o
);
  logic                          cfg_we;
  fc_wr_t [NUM_UNITS-1:0]        unit_we;
  logic [NUM_UNITS-1:0][1:0]     take;
  logic [CFG_W-1:0]              cfg_q;
  logic [NUM_UNITS-1:0]          active;

  fc_reg_decode #(.NUM_UNITS(NUM_UNITS), .ADDR_W(ADDR_W)) u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .cfg_we_o  (cfg_we),
    .unit_we_o (unit_we)
  );

  fc_consume_map #(.NUM_UNITS(NUM_UNITS)) u_map (
    .consume_i (consume_i),
    .take_o    (take)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_q <= '0;
    else if (cfg_we) cfg_q <= wr_data_i[CFG_W-1:0];
  end

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    assign active[u] = cfg_q[0] && cfg_q[u+1];
    fc_unit #(.CNT_W(CNT_W)) u_unit (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .active_i (active[u]),
      .wr_i     (unit_we[u]),
      .wdata_i  (wr_data_i),
      .take_i   (take[u]),
      .cnt_o    (credit_o[u*CNT_W +: CNT_W]),
      .bp_o     (bp_o[u])
    );
  end

  assert_master_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_q[0] |=> (bp_o == '0));
endmodule

// File: tb/fc_credit_tracker_tb_top.sv
`timescale 1ns/1ps
module fc_credit_tracker_tb_top;
  localparam int NU = 2;
  localparam int CW = 4;
  localparam int AW = 8;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2*NU-1:0] consume = '0;
  logic [NU-1:0] bp;
  logic [NU*CW-1:0] credit;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int m_cnt [NU];
  bit m_bp [NU];
  int m_lo [NU];
  int m_hi [NU];
  int m_cfg;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  fc_credit_tracker #(.NUM_UNITS(NU), .CNT_W(CW), .ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .consume_i(consume), .bp_o(bp), .credit_o(credit)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ucnt(int u);
    return int'(credit[u*CW +: CW]);
  endfunction

  task automatic cmp_all(string req);
    for (int u = 0; u < NU; u++) begin
      chk(req, ucnt(u), m_cnt[u]);
      chk(req, int'(bp[u]), int'(m_bp[u]));
    end
  endtask

  // model one clock edge from current inputs
  task automatic model_edge(bit we, int addr, logic [31:0] d, logic [2*NU-1:0] cons);
    int new_cfg = m_cfg;
    for (int u = 0; u < NU; u++) begin
      bit act = m_cfg[0] && m_cfg[u+1];
      bit al = we && (addr == 12 + 12*u);
      int add = al ? int'(d[CW-1:0]) : 0;
      int tk = int'(cons[2*u]) + int'(cons[2*u+1]);
      int t = m_cnt[u] + add;
      bit sh = 0;
      int n;
      if (al && d[31]) n = MAXC;
      else if (t < tk) begin n = 0; sh = 1; end
      else begin n = t - tk; if (n > MAXC) n = MAXC; end
      if (!act) m_bp[u] = 0;
      else begin
        if (sh) m_bp[u] = 1;
        else if (n < m_lo[u]) m_bp[u] = 1;
        else if (n >= m_hi[u]) m_bp[u] = 0;
        m_cnt[u] = n;
      end
      if (we && addr == 4 + 12*u) m_lo[u] = int'(d[CW-1:0]);
      if (we && addr == 8 + 12*u) m_hi[u] = int'(d[CW-1:0]);
    end
    if (we && addr == 0) new_cfg = int'(d[NU:0]);
    m_cfg = new_cfg;
  endtask

  task automatic step(string req, bit we, int addr, logic [31:0] d, logic [2*NU-1:0] cons);
    wr_en = we; wr_addr = AW'(addr); wr_data = d; consume = cons;
    model_edge(we, addr, d, cons);
    @(negedge clk);
    wr_en = 0; consume = '0;
    cmp_all(req);
  endtask

  task automatic wr(string req, int addr, logic [31:0] d);
    step(req, 1, addr, d, '0);
  endtask

  function automatic logic [15:0] nxt(logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int u = 0; u < NU; u++) begin m_cnt[u] = 0; m_bp[u] = 0; m_lo[u] = 0; m_hi[u] = 0; end
    m_cfg = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", int'(credit), 0);
    chk("R1", int'(bp), 0);

    // disabled: alloc and consume ignored
    wr("R3", 12, 32'd5);
    chk("R3", ucnt(0), 0);
    wr("R3", 0, 32'b010);            // unit bit without master
    wr("R3", 12, 32'd5);
    chk("R3", ucnt(0), 0);
    wr("R2", 0, 32'b011);            // master + unit0
    wr("R4", 12, 32'd5);
    chk("R4", ucnt(0), 5);
    wr("R2", 4, 32'd3);
    wr("R2", 8, 32'd6);
    step("R5", 0, 0, 0, 4'b0011);    // both channels of pair 0
    chk("R5", ucnt(0), 3);
    chk("R7", int'(bp[0]), 0);
    step("R7", 0, 0, 0, 4'b0001);
    chk("R7", ucnt(0), 2);
    chk("R7", int'(bp[0]), 1);
    wr("R7", 12, 32'd3);             // 5: between thresholds, hold
    chk("R7", int'(bp[0]), 1);
    wr("R7", 12, 32'd1);             // 6: reaches high
    chk("R7", int'(bp[0]), 0);
    step("R5", 1, 12, 32'd2, 4'b0011); // net 6+2-2
    chk("R5", ucnt(0), 6);
    wr("R4", 12, 32'd15);
    chk("R4", ucnt(0), 15);
    step("R9", 0, 0, 0, 4'b1100);    // unit1 disabled
    chk("R9", ucnt(1), 0);
    chk("R9", ucnt(0), 15);
    wr("R2", 28, 32'd9);             // unmapped
    wr("R2", 2, 32'd9);              // unaligned
    chk("R2", ucnt(0), 15);
    wr("R2", 16, 32'd0);             // unit1 low, not unit0
    wr("R2", 4, 32'd0);
    for (int i = 0; i < 8; i++) step("R5", 0, 0, 0, 4'b0011);
    chk("R5", ucnt(0), 0);
    chk("R8", int'(bp[0]), 1);       // low threshold is 0 yet underflow asserts
    step("R6", 1, 12, 32'h8000_0003, 4'b0011);
    chk("R6", ucnt(0), 15);
    wr("R3", 0, 32'b000);
    chk("R3", int'(bp[0]), 0);

    // threshold sweep with pseudo-random traffic
    for (int lo = 0; lo <= MAXC; lo++) begin
      for (int hi = 0; hi <= MAXC; hi++) begin
        wr("R7", 4, lo); wr("R7", 8, hi);
        wr("R7", 16, hi); wr("R7", 20, lo);
        wr("R3", 0, 32'b111);
        for (int k = 0; k < 30; k++) begin
          logic [31:0] d;
          int sel;
          lfsr = nxt(lfsr);
          sel = int'(lfsr[2:0]);
          d = {28'd0, lfsr[6:3]} & 32'h7;
          if (sel == 0) d[31] = lfsr[7] & lfsr[8];
          if (sel <= 2)      step("R5", 1, (lfsr[9] ? 24 : 12), d, lfsr[13:10]);
          else if (sel == 3) step("R3", 1, 0, {29'd0, lfsr[12:10] | 3'b001}, lfsr[7:4]);
          else               step("R9", 0, 0, 0, lfsr[13:10]);
        end
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule